// File: doc/BRIEF.md
# Mesh Vertex Output Sequencer

This block walks a rectangular grid of points, row by row, and drives a microcode engine once for every point. For each point it presents the column and row indices to the engine together with a one-cycle launch pulse; the engine loads the indices into its general registers, restarts its program from address zero and runs until it signals a vector-output instruction. The sequencer then captures the two 32-bit operands of that instruction. It stores them, byte-swapped, as two consecutive words at an address derived from the grid position.

A runaway program is caught by an instruction budget. When a point executes too many instructions without producing its output, the sequencer gives up on that point, raises a sticky error bit and continues with the next point. After the last point it reports the number of points in the grid and emits a one-cycle interrupt.

Top module: `mesh_vertex_seq`

## Requirements
- R1: After `start`, points are visited with the row index `coord_y` running from 0 to `v_last` inclusive in the outer loop and the column index `coord_x` running from 0 to `h_last` inclusive in the inner loop; `eng_start` pulses for one cycle per point while `coord_x`/`coord_y` hold that point's indices.
- R2: The first output word of a point goes to `(base & ~7) + 8*(128*y + x)`: the three low bits of `base_addr` are ignored, rows are 128 vertices apart and each vertex takes 8 bytes.
- R3: On `eng_vout` the sequencer writes operand A to the point address, then operand B to the point address plus 4, each with its byte order reversed (byte 0 of the operand becomes bits 31:24 of `mem_data`).
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values; a word is transferred only in a cycle where both are high.
- R5: Once the second word of a point is accepted, `last_addr` equals the address of that second word; an aborted point leaves `last_addr` unchanged.
- R6: If `INSN_LIMIT` cycles with `eng_step` high occur at one point without `eng_vout`, the point is aborted: no memory write is made for it, `err_flag` is set and the next point is launched. `INSN_LIMIT`-1 steps followed by `eng_vout` complete normally.
- R7: After the last point, `vertex_count` becomes `(h_last+1)*(v_last+1)`, `busy` falls and `irq` is high for exactly one cycle.
- R8: `start` is ignored while `busy` is high; `h_last`, `v_last` and `base_addr` are sampled only on an accepted `start`, which also clears `err_flag`.
- R9: After reset `busy`, `irq`, `eng_start`, `mem_valid` and `err_flag` are 0, and `last_addr` and `vertex_count` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a pass over the grid |
| h_last | input | COORD_W | Last column index |
| v_last | input | COORD_W | Last row index |
| base_addr | input | ADDR_W | Byte address of vertex (0,0); low three bits ignored |
| eng_start | output | 1 | One-cycle launch of the engine for the current point |
| coord_x | output | COORD_W | Column index of the current point |
| coord_y | output | COORD_W | Row index of the current point |
| eng_step | input | 1 | Engine executed one non-output instruction |
| eng_vout | input | 1 | Engine executed the vector-output instruction |
| eng_opa | input | DATA_W | Operand A of the output instruction |
| eng_opb | input | DATA_W | Operand B of the output instruction |
| mem_valid | output | 1 | Write request valid |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the write |
| busy | output | 1 | A pass is in progress |
| err_flag | output | 1 | Sticky: some point hit the instruction budget |
| last_addr | output | ADDR_W | Address of the most recent second word |
| vertex_count | output | VCOUNT_W | Number of grid points of the finished pass |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench targets a point that uses exactly the instruction budget, which must abort and write nothing, and the point beside it that stops one step short, which must write normally; a design that counts one step off either aborts the good point or hangs on the bad one. It stalls the write port at random, so a design that changes the address or data under a pending request, or swaps the word order, produces a scoreboard mismatch. It also runs a single-point grid and a grid the full 128 columns wide, so that an off-by-one in the inclusive loop limits or in the row stride shows up as a wrong vertex count or address. Finally, it changes the limits and pulses `start` mid-pass, so a design that does not latch its parameters misses points.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RUN,
    S_WR0,
    S_WR1,
    S_NEXT
  } seq_state_e;

endpackage

// File: rtl/mesh_walker.sv
module mesh_walker #(
  parameter int COORD_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               adv,
  input  logic [COORD_W-1:0] h_last,
  input  logic [COORD_W-1:0] v_last,
  output logic [COORD_W-1:0] x,
  output logic [COORD_W-1:0] y,
  output logic               at_end
);

  logic row_end;

  assign row_end = (x == h_last);
  assign at_end  = row_end && (y == v_last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      x <= '0;
      y <= '0;
    end else if (adv) begin
      if (row_end) begin
        x <= '0;
        y <= y + COORD_W'(1);
      end else begin
        x <= x + COORD_W'(1);
      end
    end
  end

endmodule

// File: rtl/vout_addr_gen.sv
module vout_addr_gen #(
  parameter int COORD_W = 7,
  parameter int ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic [ADDR_W-1:0]  addr
);

  // Row stride of 2**COORD_W vertices, 8 bytes per vertex.
  localparam int OFS_W = 2 * COORD_W + 3;

  logic [OFS_W-1:0] offset;

  assign offset = {y, x, 3'b000};
  assign addr   = (base & ~ADDR_W'(7)) + ADDR_W'(offset);

endmodule

// File: rtl/insn_limit.sv
module insn_limit #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic hit
);

  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt;

  assign hit = step && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mesh_vertex_seq.sv
module mesh_vertex_seq
  import mesh_seq_pkg::*;
#(
  parameter int COORD_W    = 7,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int VCOUNT_W   = 32,
  parameter int INSN_LIMIT = 2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [COORD_W-1:0]  h_last,
  input  logic [COORD_W-1:0]  v_last,
  input  logic [ADDR_W-1:0]   base_addr,
  output logic                eng_start,
  output logic [COORD_W-1:0]  coord_x,
  output logic [COORD_W-1:0]  coord_y,
  input  logic                eng_step,
  input  logic                eng_vout,
  input  logic [DATA_W-1:0]   eng_opa,
  input  logic [DATA_W-1:0]   eng_opb,
  output logic                mem_valid,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_data,
  input  logic                mem_ready,
  output logic                busy,
  output logic                err_flag,
  output logic [ADDR_W-1:0]   last_addr,
  output logic [VCOUNT_W-1:0] vertex_count,
  output logic                irq
);

  localparam int NBYTES = DATA_W / 8;
  localparam int PROD_W = 2 * COORD_W + 2;

  seq_state_e          state;
  logic [COORD_W-1:0]  hl_q, vl_q;
  logic [ADDR_W-1:0]   base_q;
  logic [DATA_W-1:0]   opa_sw, opb_sw, opb_q;
  logic                at_end, walk_clr, walk_adv, limit_hit;
  logic [ADDR_W-1:0]   pt_addr;
  logic [PROD_W-1:0]   vtx_prod;

  // Byte-order reversal of both operands.
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign opa_sw[8*b +: 8] = eng_opa[DATA_W-8-8*b +: 8];
    assign opb_sw[8*b +: 8] = eng_opb[DATA_W-8-8*b +: 8];
  end

  assign walk_clr = (state == S_IDLE) && start;
  assign walk_adv = (state == S_NEXT) && !at_end;

  mesh_walker #(.COORD_W(COORD_W)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .clr    (walk_clr),
    .adv    (walk_adv),
    .h_last (hl_q),
    .v_last (vl_q),
    .x      (coord_x),
    .y      (coord_y),
    .at_end (at_end)
  );

  vout_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_addr (
    .base (base_q),
    .x    (coord_x),
    .y    (coord_y),
    .addr (pt_addr)
  );

  insn_limit #(.LIMIT(INSN_LIMIT)) u_limit (
    .clk  (clk),
    .rst  (rst),
    .clr  (state != S_RUN),
    .step (eng_step && !eng_vout),
    .hit  (limit_hit)
  );

  assign vtx_prod = (PROD_W'(hl_q) + PROD_W'(1)) * (PROD_W'(vl_q) + PROD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      hl_q         <= '0;
      vl_q         <= '0;
      base_q       <= '0;
      opb_q        <= '0;
      eng_start    <= 1'b0;
      mem_valid    <= 1'b0;
      mem_addr     <= '0;
      mem_data     <= '0;
      busy         <= 1'b0;
      err_flag     <= 1'b0;
      last_addr    <= '0;
      vertex_count <= '0;
      irq          <= 1'b0;
    end else begin
      irq       <= 1'b0;
      eng_start <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            hl_q      <= h_last;
            vl_q      <= v_last;
            base_q    <= base_addr;
            err_flag  <= 1'b0;
            busy      <= 1'b1;
            eng_start <= 1'b1;
            state     <= S_RUN;
          end
        end
        S_RUN: begin
          if (eng_vout) begin
            opb_q     <= opb_sw;
            mem_valid <= 1'b1;
            mem_addr  <= pt_addr;
            mem_data  <= opa_sw;
            state     <= S_WR0;
          end else if (limit_hit) begin
            err_flag <= 1'b1;
            state    <= S_NEXT;
          end
        end
        S_WR0: begin
          if (mem_ready) begin
            mem_addr <= mem_addr + ADDR_W'(4);
            mem_data <= opb_q;
            state    <= S_WR1;
          end
        end
        S_WR1: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            last_addr <= mem_addr;
            state     <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (at_end) begin
            vertex_count <= VCOUNT_W'(vtx_prod);
            irq          <= 1'b1;
            busy         <= 1'b0;
            state        <= S_IDLE;
          end else begin
            eng_start <= 1'b1;
            state     <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mesh_vertex_seq_chk.sv
module mesh_vertex_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              irq,
  input logic              eng_start,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [ADDR_W-1:0] last_addr
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy);  // R1

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[1:0] == 2'b00));  // R2

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_addr[2]) |=>
      (mem_valid && (mem_addr == $past(mem_addr) + ADDR_W'(4))));  // R3

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data)));  // R4

  AST_LAST_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_addr[2]) |=>
      (!mem_valid && (last_addr == $past(mem_addr))));  // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);  // R7

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_valid && !eng_start));  // R8

endmodule

bind mesh_vertex_seq mesh_vertex_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .irq       (irq),
  .eng_start (eng_start),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .last_addr (last_addr)
);

// File: tb/mesh_vertex_seq_test.sv
module mesh_vertex_seq_test;

  localparam int CW  = 7;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int VW  = 32;
  localparam int LIM = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] h_last = '0, v_last = '0;
  logic [AW-1:0] base_addr = '0;
  logic          eng_start;
  logic [CW-1:0] coord_x, coord_y;
  logic          eng_step = 1'b0, eng_vout = 1'b0;
  logic [DW-1:0] eng_opa = '0, eng_opb = '0;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_ready = 1'b0;
  logic          busy, err_flag, irq;
  logic [AW-1:0] last_addr;
  logic [VW-1:0] vertex_count;

  always #10 clk = ~clk;

  mesh_vertex_seq #(
    .COORD_W(CW), .ADDR_W(AW), .DATA_W(DW), .VCOUNT_W(VW), .INSN_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .h_last(h_last), .v_last(v_last),
    .base_addr(base_addr), .eng_start(eng_start), .coord_x(coord_x),
    .coord_y(coord_y), .eng_step(eng_step), .eng_vout(eng_vout),
    .eng_opa(eng_opa), .eng_opb(eng_opb), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .busy(busy), .err_flag(err_flag), .last_addr(last_addr),
    .vertex_count(vertex_count), .irq(irq)
  );

  int n_checks = 0;
  int n_fail = 0;
  int writes_seen = 0;
  logic [AW-1:0] exp_addr_q[$];
  logic [DW-1:0] exp_data_q[$];
  logic [AW-1:0] exp_last = '0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  function automatic logic [DW-1:0] bswap(input logic [DW-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [AW-1:0] vaddr(input logic [AW-1:0] base, input int x, input int y);
    return (base & ~32'h7) + AW'(8 * (128 * y + x));
  endfunction

  // Memory responder with random back-pressure and scoreboard.
  initial begin
    logic          pend = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [DW-1:0] pd = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        chk("R4", "held addr under stall", mem_addr, pa);
        chk("R4", "held data under stall", mem_data, pd);
        chk("R4", "held valid under stall", mem_valid, 1);
      end
      if (mem_valid) begin
        mem_ready = (($urandom % 3) != 0);
        if (mem_ready) begin
          writes_seen++;
          if (exp_addr_q.size() == 0) begin
            chk("R6", "unexpected write", 1, 0);
          end else begin
            chk("R2", "write address", mem_addr, exp_addr_q.pop_front());
            chk("R3", "write data", mem_data, exp_data_q.pop_front());
          end
        end
        pend = !mem_ready;
        pa   = mem_addr;
        pd   = mem_data;
      end else begin
        mem_ready = 1'b0;
        pend      = 1'b0;
      end
    end
  end

  task automatic run_engine(input int hl, input int vl, input logic [AW-1:0] base,
                            input int abort_idx, input int edge_idx);
    int idx = 0;
    for (int y = 0; y <= vl; y++) begin
      for (int x = 0; x <= hl; x++) begin
        int nsteps;
        while (!eng_start) @(negedge clk);
        chk("R1", "coord_x at launch", coord_x, x);
        chk("R1", "coord_y at launch", coord_y, y);
        if (idx == abort_idx)      nsteps = LIM;
        else if (idx == edge_idx)  nsteps = LIM - 1;
        else                       nsteps = int'($urandom % 4);
        for (int s = 0; s < nsteps; s++) begin
          if (($urandom % 2) == 1) begin
            eng_step = 1'b0;
            @(negedge clk);
          end
          eng_step = 1'b1;
          @(negedge clk);
        end
        eng_step = 1'b0;
        if (idx == abort_idx) begin
          if (nsteps > 0) ;
        end else begin
          logic [DW-1:0] a, b;
          logic [AW-1:0] pa;
          a  = $urandom;
          b  = $urandom;
          pa = vaddr(base, x, y);
          exp_addr_q.push_back(pa);
          exp_data_q.push_back(bswap(a));
          exp_addr_q.push_back(pa + 4);
          exp_data_q.push_back(bswap(b));
          exp_last = pa + 4;
          eng_vout = 1'b1;
          eng_opa  = a;
          eng_opb  = b;
          @(negedge clk);
          eng_vout = 1'b0;
        end
        idx++;
      end
    end
  endtask

  task automatic run_case(input int hl, input int vl, input logic [AW-1:0] base,
                          input int abort_idx, input int edge_idx,
                          input bit poke, input bit exp_err);
    int wstart = writes_seen;
    int npts = (hl + 1) * (vl + 1);
    int good = npts - ((abort_idx >= 0) ? 1 : 0);
    int w = 0;
    h_last    = CW'(hl);
    v_last    = CW'(vl);
    base_addr = base;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8", "busy after start", busy, 1);
    chk("R8", "err cleared by start", err_flag, 0);
    // Inputs change mid-pass; the latched values must govern.
    h_last    = '0;
    v_last    = '0;
    base_addr = $urandom;
    fork
      run_engine(hl, vl, base, abort_idx, edge_idx);
      begin
        if (poke) begin
          repeat (20) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    while (!irq && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk("R7", "irq raised", irq, 1);
    chk("R7", "vertex count", vertex_count, npts);
    chk("R7", "busy low at end", busy, 0);
    chk("R6", "error flag", err_flag, exp_err);
    chk("R5", "last address", last_addr, exp_last);
    chk("R6", "words written", writes_seen - wstart, 2 * good);
    chk("R8", "scoreboard drained", exp_addr_q.size(), 0);
    @(negedge clk);
    chk("R7", "irq single cycle", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "busy after reset", busy, 0);
    chk("R9", "irq after reset", irq, 0);
    chk("R9", "eng_start after reset", eng_start, 0);
    chk("R9", "mem_valid after reset", mem_valid, 0);
    chk("R9", "err after reset", err_flag, 0);
    chk("R9", "last_addr after reset", last_addr, 0);
    chk("R9", "vertex_count after reset", vertex_count, 0);
    // 4x3 grid, unaligned base, abort at point 5, budget edge at point 6.
    run_case(3, 2, 32'h1000_0005, 5, 6, 1'b1, 1'b1);
    // Single point; err from the previous pass must be cleared.
    run_case(0, 0, 32'h0000_2003, -1, -1, 1'b0, 1'b0);
    // Full-width rows, budget edge on the first point.
    run_case(127, 1, 32'h8000_0000, -1, 0, 1'b0, 1'b0);
    summary();
    $finish;
  end

endmodule